// File: doc/BRIEF.md
# Execute-Chain Sequencer

This block sits in a processor's fetch path and handles the instruction that says "run the word found at my effective address". When such an instruction arrives from normal sequencing, the sequencer records its address and fetches the word at its effective address. If that word is another execute instruction, it fetches again from the new effective address. It repeats this for as many links as the program builds, and the program counter never moves while it does so. The first word that is not an execute instruction goes to execution as the subject.

When the subject completes, the sequencer sends one redirect. The redirect either continues after the first execute instruction or goes to the target the subject supplies, when the subject is a taken branch or loads or exchanges the program status. An interrupt accepted at any fetch of the chain, or before the subject's last interruptible point, abandons the chain. Its resume address is the first execute instruction, so the whole chain runs again later. A trap at any point saves that same first address. Datapath, memory, effective-address arithmetic and interrupt priority are outside the block.

Top module: `xc_seq_ctrl`

## Requirements
- R1: While idle, `issue_valid` with `issue_is_exec`=1 starts a chain. One cycle later `fetch_req`=1, `fetch_addr` equals the sampled `issue_ea`, `busy`=1 and `chain_depth`=1. An issue with `issue_is_exec`=0 starts nothing.
- R2: During a fetch, a response with `rsp_valid`=1 and `rsp_is_exec`=1, and with no trap or interrupt in that cycle, leads one cycle later to a further fetch at the sampled `rsp_ea`. `chain_depth` rises by one and saturates at 2^DW-1. No redirect is issued.
- R3: During a fetch, a response with `rsp_is_exec`=0, and with no trap or interrupt, leads one cycle later to `subj_valid`=1 with `subj_word` equal to the sampled `rsp_word`. `fetch_req` and `subj_valid` are never high together.
- R4: `subj_done` with `subj_taken`=0 gives, one cycle later, a redirect of kind 2'b00 to the first execute instruction's address plus one, modulo 2^AW.
- R5: `subj_done` with `subj_taken`=1 gives, one cycle later, a redirect of kind 2'b01 to the sampled `subj_target`.
- R6: `irq_req` high in any fetch cycle of the chain gives, one cycle later, a redirect of kind 2'b10 whose address is the first execute instruction. The chain is abandoned, even when a response arrives in the same cycle.
- R7: While the subject is outstanding, `irq_req` with `subj_intr`=1 acts as in R6. With `subj_intr`=0 the interrupt request is ignored.
- R8: `trap_evt` while busy gives, one cycle later, a redirect of kind 2'b11 whose address is the first execute instruction. It wins over an interrupt, a response or a completion in the same cycle.
- R9: While idle, `rsp_valid`, `subj_done`, `irq_req` and `trap_evt` have no effect: no fetch, no subject and no redirect follow.
- R10: `redir_valid` is a single-cycle pulse. In that cycle `busy`=0 and `chain_depth`=0, and a new chain may start from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered from normal sequencing |
| issue_is_exec | input | 1 | Offered instruction is an execute instruction |
| issue_pc | input | AW | Address of the offered instruction |
| issue_ea | input | AW | Effective address of the offered instruction |
| fetch_req | output | 1 | Chain fetch in progress |
| fetch_addr | output | AW | Address being fetched |
| rsp_valid | input | 1 | Fetched word available |
| rsp_is_exec | input | 1 | Fetched word decodes as an execute instruction |
| rsp_ea | input | AW | Effective address of the fetched word |
| rsp_word | input | WW | Fetched word |
| subj_valid | output | 1 | Subject instruction handed to execution |
| subj_word | output | WW | Subject instruction word |
| subj_intr | input | 1 | Subject still before its last interruptible point |
| subj_done | input | 1 | Subject finished |
| subj_taken | input | 1 | Subject redirects (taken branch or status load/exchange) |
| subj_target | input | AW | Subject's redirect address |
| irq_req | input | 1 | Interrupt activation request |
| trap_evt | input | 1 | Trap condition |
| redir_valid | output | 1 | Redirect pulse |
| redir_kind | output | 2 | 00 sequential, 01 subject target, 10 interrupt resume, 11 trap save |
| redir_pc | output | AW | Redirect address |
| busy | output | 1 | Chain or subject outstanding |
| chain_depth | output | DW | Execute instructions followed so far |

## Verification
The hardest case to reach is an interrupt or trap that lands in the middle of a long chain. It must arrive in the same cycle as a fetch response, because that is where the priority between abandoning the chain and following it matters. The stimulus drives chains of 1, 2, 5 and 258 links with stalled responses. It injects the interrupt or trap on a chosen link together with a valid response, and in the subject phase it raises interrupts both inside and outside the interruptible window. Chain depth saturation is reached with the 258-link chain.

// File: rtl/xc_pkg.sv
package xc_pkg;
   typedef enum logic [1:0] {
      RD_SEQ    = 2'b00,
      RD_BRANCH = 2'b01,
      RD_IRQ    = 2'b10,
      RD_TRAP   = 2'b11
   } redir_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_FETCH = 2'b01,
      ST_SUBJ  = 2'b10
   } seq_state_e;
endpackage

// File: rtl/xc_depth_ctr.sv
module xc_depth_ctr #(
   parameter int DW       = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load_one,
   input  logic          inc,
   output logic [DW-1:0] depth
);
   localparam logic [DW-1:0] MAXV = {DW{1'b1}};

   logic [DW-1:0] cnt_q;
   logic [DW-1:0] cnt_inc;

   if (DW < 1) begin : g_bad_dw
      $error("xc_depth_ctr: DW must be at least 1");
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb cnt_inc = (cnt_q == MAXV) ? cnt_q : cnt_q + DW'(1);
      end else begin : g_wrap
         always_comb cnt_inc = cnt_q + DW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (load_one) cnt_q <= DW'(1);
      else if (inc)      cnt_q <= cnt_inc;
   end

   assign depth = cnt_q;

   AST_DEPTH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (depth == '0)); // R10
endmodule

// File: rtl/xc_addr_track.sv
module xc_addr_track
   import xc_pkg::*;
#(
   parameter int AW   = 16,
   parameter int STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          start,
   input  logic [AW-1:0] issue_pc,
   input  logic [AW-1:0] issue_ea,
   input  logic          step,
   input  logic [AW-1:0] rsp_ea,
   input  logic          fire,
   input  redir_kind_e   kind,
   input  logic [AW-1:0] subj_target,
   output logic [AW-1:0] fetch_addr,
   output logic [AW-1:0] redir_pc
);
   logic [AW-1:0] head_q;
   logic [AW-1:0] fa_q;
   logic [AW-1:0] rpc_q;
   logic [AW-1:0] ret_pc;

   if (AW < 2) begin : g_bad_aw
      $error("xc_addr_track: AW must be at least 2");
   end
   if (STEP < 1) begin : g_bad_step
      $error("xc_addr_track: STEP must be at least 1");
   end

   assign ret_pc = head_q + AW'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         fa_q   <= '0;
         rpc_q  <= '0;
      end else begin
         if (start) begin
            head_q <= issue_pc;
            fa_q   <= issue_ea;
         end else if (step) begin
            fa_q   <= rsp_ea;
         end
         if (fire) begin
            unique case (kind)
               RD_SEQ:    rpc_q <= ret_pc;
               RD_BRANCH: rpc_q <= subj_target;
               default:   rpc_q <= head_q;
            endcase
         end
      end
   end

   assign fetch_addr = fa_q;
   assign redir_pc   = rpc_q;

   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(head_q)); // R8
endmodule

// File: rtl/xc_chain_fsm.sv
module xc_chain_fsm
   import xc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        rsp_valid,
   input  logic        rsp_is_exec,
   input  logic        subj_intr,
   input  logic        subj_done,
   input  logic        subj_taken,
   input  logic        irq_req,
   input  logic        trap_evt,
   output seq_state_e  state,
   output logic        fire,
   output redir_kind_e kind,
   output logic        step,
   output logic        load_subj
);
   seq_state_e st_q, st_d;

   always_comb begin
      st_d      = st_q;
      fire      = 1'b0;
      kind      = RD_SEQ;
      step      = 1'b0;
      load_subj = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) st_d = ST_FETCH;
         end
         ST_FETCH: begin
            if (trap_evt) begin
               fire = 1'b1;
               kind = RD_TRAP;
            end else if (irq_req) begin
               fire = 1'b1;
               kind = RD_IRQ;
            end else if (rsp_valid) begin
               if (rsp_is_exec) begin
                  step = 1'b1;
               end else begin
                  load_subj = 1'b1;
                  st_d      = ST_SUBJ;
               end
            end
         end
         ST_SUBJ: begin
            if (trap_evt) begin
               fire = 1'b1;
               kind = RD_TRAP;
            end else if (irq_req && subj_intr) begin
               fire = 1'b1;
               kind = RD_IRQ;
            end else if (subj_done) begin
               fire = 1'b1;
               kind = subj_taken ? RD_BRANCH : RD_SEQ;
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (fire) st_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state = st_q;

   AST_SUBJ_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SUBJ && $past(st_q) != ST_SUBJ) |-> ($past(st_q) == ST_FETCH)); // R3
endmodule

// File: rtl/xc_seq_ctrl.sv
module xc_seq_ctrl
   import xc_pkg::*;
#(
   parameter int AW        = 16,
   parameter int WW        = 32,
   parameter int DW        = 8,
   parameter int STEP      = 1,
   parameter bit DEPTH_SAT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue_valid,
   input  logic          issue_is_exec,
   input  logic [AW-1:0] issue_pc,
   input  logic [AW-1:0] issue_ea,
   output logic          fetch_req,
   output logic [AW-1:0] fetch_addr,
   input  logic          rsp_valid,
   input  logic          rsp_is_exec,
   input  logic [AW-1:0] rsp_ea,
   input  logic [WW-1:0] rsp_word,
   output logic          subj_valid,
   output logic [WW-1:0] subj_word,
   input  logic          subj_intr,
   input  logic          subj_done,
   input  logic          subj_taken,
   input  logic [AW-1:0] subj_target,
   input  logic          irq_req,
   input  logic          trap_evt,
   output logic          redir_valid,
   output logic [1:0]    redir_kind,
   output logic [AW-1:0] redir_pc,
   output logic          busy,
   output logic [DW-1:0] chain_depth
);
   if (WW < 1) begin : g_bad_ww
      $error("xc_seq_ctrl: WW must be at least 1");
   end

   seq_state_e  state;
   logic        fire, step, load_subj, start_chain;
   redir_kind_e kind;
   logic        rv_q;
   redir_kind_e rk_q;
   logic [WW-1:0] word_q;

   assign busy        = (state != ST_IDLE);
   assign start_chain = issue_valid && issue_is_exec && !busy;
   assign fetch_req   = (state == ST_FETCH);
   assign subj_valid  = (state == ST_SUBJ);

   xc_chain_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_chain),
      .rsp_valid  (rsp_valid),
      .rsp_is_exec(rsp_is_exec),
      .subj_intr  (subj_intr),
      .subj_done  (subj_done),
      .subj_taken (subj_taken),
      .irq_req    (irq_req),
      .trap_evt   (trap_evt),
      .state      (state),
      .fire       (fire),
      .kind       (kind),
      .step       (step),
      .load_subj  (load_subj)
   );

   xc_addr_track #(.AW(AW), .STEP(STEP)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .start      (start_chain),
      .issue_pc   (issue_pc),
      .issue_ea   (issue_ea),
      .step       (step),
      .rsp_ea     (rsp_ea),
      .fire       (fire),
      .kind       (kind),
      .subj_target(subj_target),
      .fetch_addr (fetch_addr),
      .redir_pc   (redir_pc)
   );

   xc_depth_ctr #(.DW(DW), .SATURATE(DEPTH_SAT)) u_depth (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fire),
      .load_one(start_chain),
      .inc     (step),
      .depth   (chain_depth)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rv_q   <= 1'b0;
         rk_q   <= RD_SEQ;
         word_q <= '0;
      end else begin
         rv_q <= fire;
         if (fire)      rk_q   <= kind;
         if (load_subj) word_q <= rsp_word;
      end
   end

   assign redir_valid = rv_q;
   assign redir_kind  = rk_q;
   assign subj_word   = word_q;

   AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && issue_valid && issue_is_exec) |=>
      (fetch_req && fetch_addr == $past(issue_ea) && chain_depth == DW'(1))); // R1
   AST_CHAIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && rsp_valid && rsp_is_exec && !trap_evt && !irq_req) |=>
      (fetch_req && fetch_addr == $past(rsp_ea) && !redir_valid)); // R2
   AST_DEPTH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (chain_depth != '0)); // R2
   AST_SUBJ_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && rsp_valid && !rsp_is_exec && !trap_evt && !irq_req) |=>
      (subj_valid && subj_word == $past(rsp_word))); // R3
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_req && subj_valid)); // R3
   AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (subj_valid && subj_done && subj_taken && !trap_evt && !(irq_req && subj_intr)) |=>
      (redir_valid && redir_kind == 2'b01 && redir_pc == $past(subj_target))); // R5
   AST_IRQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && irq_req && !trap_evt) |=> (redir_valid && redir_kind == 2'b10)); // R6
   AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trap_evt) |=> (redir_valid && redir_kind == 2'b11)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(issue_valid && issue_is_exec)) |=> (!redir_valid && !busy)); // R9
   AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (!busy && chain_depth == '0)); // R10
endmodule

// File: tb/xc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module xc_seq_ctrl_tb_top;
   localparam int AW   = 16;
   localparam int WW   = 32;
   localparam int DW   = 8;
   localparam int MAXD = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_valid = 0, issue_is_exec = 0;
   logic [AW-1:0] issue_pc = '0, issue_ea = '0;
   logic          fetch_req;
   logic [AW-1:0] fetch_addr;
   logic          rsp_valid = 0, rsp_is_exec = 0;
   logic [AW-1:0] rsp_ea = '0;
   logic [WW-1:0] rsp_word = '0;
   logic          subj_valid;
   logic [WW-1:0] subj_word;
   logic          subj_intr = 0, subj_done = 0, subj_taken = 0;
   logic [AW-1:0] subj_target = '0;
   logic          irq_req = 0, trap_evt = 0;
   logic          redir_valid;
   logic [1:0]    redir_kind;
   logic [AW-1:0] redir_pc;
   logic          busy;
   logic [DW-1:0] chain_depth;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   xc_seq_ctrl #(.AW(AW), .WW(WW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_is_exec(issue_is_exec),
      .issue_pc(issue_pc), .issue_ea(issue_ea),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .rsp_valid(rsp_valid), .rsp_is_exec(rsp_is_exec),
      .rsp_ea(rsp_ea), .rsp_word(rsp_word),
      .subj_valid(subj_valid), .subj_word(subj_word),
      .subj_intr(subj_intr), .subj_done(subj_done),
      .subj_taken(subj_taken), .subj_target(subj_target),
      .irq_req(irq_req), .trap_evt(trap_evt),
      .redir_valid(redir_valid), .redir_kind(redir_kind),
      .redir_pc(redir_pc), .busy(busy), .chain_depth(chain_depth)
   );

   // behavioural reference: phase 0 idle, 1 fetching, 2 subject out
   int    m_ph, m_head, m_fa, m_dep, m_rv, m_kind, m_rpc;
   longint m_word;
   string m_tag = "R9";

   task automatic m_redirect(input int k, input int pc, input string tag);
      m_rv = 1; m_kind = k; m_rpc = pc; m_ph = 0; m_dep = 0; m_tag = tag;
   endtask

   always @(posedge clk) begin
      m_rv = 0;
      if (!rst_n) begin
         m_ph = 0; m_head = 0; m_fa = 0; m_dep = 0; m_word = 0; m_tag = "R9";
      end else begin
         case (m_ph)
            0: if (issue_valid && issue_is_exec) begin
                  m_head = int'(issue_pc); m_fa = int'(issue_ea); m_dep = 1; m_ph = 1; m_tag = "R1";
               end else m_tag = "R9";
            1: if (trap_evt) m_redirect(3, m_head, "R8");
               else if (irq_req) m_redirect(2, m_head, "R6");
               else if (rsp_valid) begin
                  if (rsp_is_exec) begin
                     m_fa = int'(rsp_ea);
                     if (m_dep < MAXD) m_dep++;
                     m_tag = "R2";
                  end else begin
                     m_word = longint'(rsp_word); m_ph = 2; m_tag = "R3";
                  end
               end
            default: if (trap_evt) m_redirect(3, m_head, "R8");
               else if (irq_req && subj_intr) m_redirect(2, m_head, "R7");
               else if (subj_done) begin
                  if (subj_taken) m_redirect(1, int'(subj_target), "R5");
                  else m_redirect(0, (m_head + 1) % (1 << AW), "R4");
               end else if (irq_req) m_tag = "R7";
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!finished) begin
         chk(fetch_req == (m_ph == 1), m_tag, "fetch_req", fetch_req, m_ph == 1);
         if (m_ph == 1) chk(int'(fetch_addr) == m_fa, m_tag, "fetch_addr", fetch_addr, m_fa);
         chk(subj_valid == (m_ph == 2), m_tag, "subj_valid", subj_valid, m_ph == 2);
         if (m_ph == 2) chk(longint'(subj_word) == m_word, m_tag, "subj_word", subj_word, m_word);
         chk(redir_valid == m_rv[0], m_tag, "redir_valid", redir_valid, m_rv);
         if (m_rv != 0) begin
            chk(int'(redir_kind) == m_kind, m_tag, "redir_kind", redir_kind, m_kind);
            chk(int'(redir_pc) == m_rpc, m_tag, "redir_pc", redir_pc, m_rpc);
            chk(!busy && chain_depth == '0, "R10", "busy/depth at pulse", {busy, chain_depth}, 0);
         end
         chk(busy == (m_ph != 0), m_tag, "busy", busy, m_ph != 0);
         chk(int'(chain_depth) == m_dep, m_tag, "chain_depth", chain_depth, m_dep);
      end
   end

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // smode: 0 done, 1 irq inside window, 2 trap with done, 3 irq outside window then done
   task automatic run_chain(input int pc, input int n, input int stall, input int irq_k,
                            input int trap_k, input int smode, input bit taken);
      @(negedge clk);
      issue_valid = 1; issue_is_exec = 1;
      issue_pc = AW'(pc); issue_ea = AW'($urandom);
      @(negedge clk);
      issue_valid = 0;
      for (int k = 1; k <= n; k++) begin
         repeat (stall) @(negedge clk);
         rsp_valid = 1; rsp_is_exec = (k < n);
         rsp_ea = AW'($urandom); rsp_word = $urandom;
         if (k == irq_k)  irq_req = 1;
         if (k == trap_k) trap_evt = 1;
         @(negedge clk);
         rsp_valid = 0; irq_req = 0; trap_evt = 0;
         if (k == irq_k || k == trap_k) begin
            idle_cycles(2);
            return;
         end
      end
      idle_cycles(2);
      if (smode == 3) begin
         irq_req = 1; subj_intr = 0;
         @(negedge clk);
         irq_req = 0;
         idle_cycles(1);
      end
      if (smode == 1) begin
         irq_req = 1; subj_intr = 1;
      end else begin
         subj_done = 1; subj_taken = taken; subj_target = AW'($urandom);
         if (smode == 2) begin trap_evt = 1; irq_req = 1; subj_intr = 1; end
      end
      @(negedge clk);
      irq_req = 0; subj_intr = 0; subj_done = 0; subj_taken = 0; trap_evt = 0;
      idle_cycles(2);
   endtask

   initial begin
      idle_cycles(3);
      rst_n = 1;
      idle_cycles(2);
      // R9: idle noise and a non-execute issue
      rsp_valid = 1; rsp_is_exec = 1; subj_done = 1; irq_req = 1; trap_evt = 1;
      issue_valid = 1; issue_is_exec = 0;
      @(negedge clk);
      rsp_valid = 0; rsp_is_exec = 0; subj_done = 0; irq_req = 0; trap_evt = 0; issue_valid = 0;
      idle_cycles(2);
      run_chain(16'h0100, 1, 0, 0, 0, 0, 0);     // R4 length 1
      run_chain(16'h0200, 2, 1, 0, 0, 0, 1);     // R5 length 2
      run_chain(16'h0300, 5, 2, 0, 0, 0, 0);     // R2 R4 length 5
      run_chain(16'h0400, 5, 0, 3, 0, 0, 0);     // R6 mid-chain
      run_chain(16'h0500, 2, 0, 1, 0, 0, 0);     // R6 first fetch
      run_chain(16'h0600, 1, 1, 1, 0, 0, 0);     // R6 with subject response
      run_chain(16'h0700, 2, 0, 0, 0, 3, 0);     // R7 outside window, then R4
      run_chain(16'h0800, 5, 0, 0, 0, 1, 0);     // R7 inside window
      run_chain(16'h0900, 5, 0, 4, 4, 0, 0);     // R8 over irq in fetch
      run_chain(16'h0A00, 2, 0, 0, 0, 2, 1);     // R8 over done in subject
      run_chain(16'hFFFF, 1, 0, 0, 0, 0, 0);     // R4 wrap
      run_chain(16'h0B00, 258, 0, 0, 0, 0, 1);   // R2 saturation
      // R10: restart in the redirect cycle
      @(negedge clk);
      issue_valid = 1; issue_is_exec = 1; issue_pc = 16'h0C00; issue_ea = 16'h1234;
      @(negedge clk);
      issue_valid = 0;
      rsp_valid = 1; rsp_is_exec = 0; rsp_word = 32'hCAFE0001;
      @(negedge clk);
      rsp_valid = 0; subj_done = 1;
      @(negedge clk);
      subj_done = 0;
      issue_valid = 1; issue_is_exec = 1; issue_pc = 16'h0D00; issue_ea = 16'h4321;
      @(negedge clk);
      issue_valid = 0; trap_evt = 1;
      @(negedge clk);
      trap_evt = 0;
      idle_cycles(3);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule